// File: doc/BRIEF.md
# Timestamp Queue Register Bank

This block gives software a 32-bit memory-mapped window onto two timestamp queues, one for received frames and one for transmitted frames. Each direction owns an eight-word window that holds a control word, a status word with the queue occupancy, two scratch words and four words that hold one 128-bit record taken from the queue.

Software fetches a record in three steps. It writes zero to the control word, writes it again with the fetch bit set, and then polls the control word until bit 0 reads as 1. It then reads the four record words. Bit 0 of the control word is a request bit when written and a completion flag when read. A 0-to-1 change of that bit arms one fetch. The armed fetch takes exactly one entry from the queue as soon as the queue offers one, and then sets the flag. Writing the bit back to zero clears the flag and disarms any fetch that is still waiting. Bit 1 of the control word is driven out as a level that empties the queue.

The queue side is a valid/ready stream for each direction. The queue holds `*_valid` high while its head entry is present on `*_data`. The bank raises `*_ready` for one cycle to take that entry, and the transfer happens on the clock edge where both are high. The bank never raises ready without valid, and it accepts at most one entry for each armed fetch, so the queue sees back-pressure until software asks for the next record. The count and flush signals are plain levels.

Top module: `tsq_regbank`

## Requirements
- R1: After reset all stored words, the completion flags and `bus_rdata` are zero, and no ready or flush output is high.
- R2: `bus_rdata` takes the value of the addressed word on the clock edge that samples `bus_rd` high. It holds its value in every cycle in which `bus_rd` is low.
- R3: A write to the control word (window offset 0x00) stores all 32 bits. A read returns bits 31:1 as stored and bit 0 as the completion flag. Stored bit 1 drives the flush output of that direction.
- R4: The status word (offset 0x04) reads the queue count in bits 7:0 and zero in bits 31:8.
- R5: A write that changes bit 0 of the control word from 0 to 1 arms one fetch. The fetch takes exactly one entry (ready high for a single cycle while valid is high), latches that entry as the record, and sets the completion flag.
- R6: A fetch that is armed while the queue is empty waits, and takes the first entry that becomes valid.
- R7: Writing bit 0 as 1 while the stored bit is already 1 arms no fetch and leaves the flag unchanged.
- R8: Writing bit 0 as 0 clears the flag and disarms a pending fetch. If that write falls in the same cycle in which a pending fetch would take an entry, the write wins and no entry is taken.
- R9: While stored bit 1 is set, no entry is taken and a pending fetch is disarmed.
- R10: The record reads at offsets 0x10, 0x14, 0x18 and 0x1C, as record bits 127:96, 95:64, 63:32 and 31:0 in that order.
- R11: Offsets 0x08 and 0x0C are scratch words that read back what was written.
- R12: The receive window is at 0x40 and the transmit window at 0x60. They have the same layout and work independently.
- R13: Any address outside both windows, or with bits 1:0 nonzero, reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rxq_valid | input | 1 | Receive queue head entry present |
| rxq_ready | output | 1 | Take receive head entry |
| rxq_data | input | 128 | Receive head entry |
| rxq_count | input | 8 | Receive queue occupancy |
| rxq_flush | output | 1 | Empty the receive queue |
| txq_valid | input | 1 | Transmit queue head entry present |
| txq_ready | output | 1 | Take transmit head entry |
| txq_data | input | 128 | Transmit head entry |
| txq_count | input | 8 | Transmit queue occupancy |
| txq_flush | output | 1 | Empty the transmit queue |

## Verification
Two things can land in the same cycle: the bus write that clears the request bit, and the cycle in which an armed fetch would take an entry. The bench arms a fetch while its model queue is empty. It then pushes an entry in the very cycle in which it writes the control word to zero. The run passes only if the model queue sees no take, the occupancy stays at one, and the control word reads bit 0 as 0. A following normal fetch must then return that same entry.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int NDIR   = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  // word slot inside one eight-word direction window
  typedef enum logic [2:0] {
    W_CTRL = 3'd0,
    W_STAT = 3'd1,
    W_SCR0 = 3'd2,
    W_SCR1 = 3'd3,
    W_REC0 = 3'd4,
    W_REC1 = 3'd5,
    W_REC2 = 3'd6,
    W_REC3 = 3'd7
  } word_e;
endpackage

// File: rtl/tsq_addr_dec.sv
module tsq_addr_dec
  import tsq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RX_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] TX_BASE = 8'h60
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NDIR-1:0]   hit,
  output word_e             sel
);
  localparam int WIN_LSB = 5;
  logic aligned;

  assign aligned = (addr[1:0] == 2'b00);
  assign hit[DIR_RX] = aligned && (addr[ADDR_W-1:WIN_LSB] == RX_BASE[ADDR_W-1:WIN_LSB]);
  assign hit[DIR_TX] = aligned && (addr[ADDR_W-1:WIN_LSB] == TX_BASE[ADDR_W-1:WIN_LSB]);
  assign sel = word_e'(addr[WIN_LSB-1:2]);
endmodule

// File: rtl/tsq_dir_regs.sv
module tsq_dir_regs
  import tsq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REC_W  = 128,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  word_e             sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              q_valid,
  input  logic [REC_W-1:0]  q_data,
  input  logic [CNT_W-1:0]  q_count,
  output logic              q_ready,
  output logic              q_flush,
  output logic [DATA_W-1:0] rd_word,
  output logic              done_o
);
  localparam int N_WORDS = REC_W / DATA_W;
  localparam int N_SCR   = 2;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] scr_q [N_SCR];
  logic [REC_W-1:0]  rec_q;
  logic              pending_q;
  logic              done_q;
  logic              ctrl_wr, arm, cancel;

  assign ctrl_wr = wr_en && (sel == W_CTRL);
  assign arm     = ctrl_wr && wdata[0] && !ctrl_q[0];
  assign cancel  = ctrl_wr && !wdata[0];
  assign q_flush = ctrl_q[1];
  assign q_ready = pending_q && q_valid && !cancel && !q_flush;
  assign done_o  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      pending_q <= 1'b0;
      done_q    <= 1'b0;
      rec_q     <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (cancel || q_flush)  pending_q <= 1'b0;
      else if (arm)           pending_q <= 1'b1;
      else if (q_ready)       pending_q <= 1'b0;
      if (cancel)             done_q <= 1'b0;
      else if (q_ready)       done_q <= 1'b1;
      if (q_ready)            rec_q <= q_data;
    end
  end

  for (genvar s = 0; s < N_SCR; s++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rst_n) scr_q[s] <= '0;
      else if (wr_en && (sel == word_e'(int'(W_SCR0) + s))) scr_q[s] <= wdata;
    end
  end

  logic [1:0] rec_idx;
  assign rec_idx = sel[1:0];

  always_comb begin
    unique case (sel)
      W_CTRL: rd_word = {ctrl_q[DATA_W-1:1], done_q};
      W_STAT: rd_word = {{(DATA_W-CNT_W){1'b0}}, q_count};
      W_SCR0: rd_word = scr_q[0];
      W_SCR1: rd_word = scr_q[1];
      default: rd_word = rec_q[(N_WORDS-1-int'(rec_idx))*DATA_W +: DATA_W];
    endcase
  end
endmodule

// File: rtl/tsq_rd_mux.sv
module tsq_rd_mux
  import tsq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [NDIR-1:0]   hit,
  input  logic [DATA_W-1:0] word_rx,
  input  logic [DATA_W-1:0] word_tx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    if (hit[DIR_RX])      nxt = word_rx;
    else if (hit[DIR_TX]) nxt = word_tx;
    else                  nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= nxt;
  end
endmodule

// File: rtl/tsq_regbank.sv
module tsq_regbank
  import tsq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REC_W  = 128,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] RX_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] TX_BASE = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rxq_valid,
  output logic              rxq_ready,
  input  logic [REC_W-1:0]  rxq_data,
  input  logic [CNT_W-1:0]  rxq_count,
  output logic              rxq_flush,
  input  logic              txq_valid,
  output logic              txq_ready,
  input  logic [REC_W-1:0]  txq_data,
  input  logic [CNT_W-1:0]  txq_count,
  output logic              txq_flush
);
  logic [NDIR-1:0]   hit;
  word_e             sel;
  logic [NDIR-1:0]   valid_v, ready_v, flush_v, done_v;
  logic [REC_W-1:0]  data_v  [NDIR];
  logic [CNT_W-1:0]  count_v [NDIR];
  logic [DATA_W-1:0] word_v  [NDIR];

  assign valid_v          = {txq_valid, rxq_valid};
  assign data_v[DIR_RX]   = rxq_data;
  assign data_v[DIR_TX]   = txq_data;
  assign count_v[DIR_RX]  = rxq_count;
  assign count_v[DIR_TX]  = txq_count;
  assign rxq_ready        = ready_v[DIR_RX];
  assign txq_ready        = ready_v[DIR_TX];
  assign rxq_flush        = flush_v[DIR_RX];
  assign txq_flush        = flush_v[DIR_TX];

  tsq_addr_dec #(.ADDR_W(ADDR_W), .RX_BASE(RX_BASE), .TX_BASE(TX_BASE)) u_dec (
    .addr(bus_addr), .hit(hit), .sel(sel)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    tsq_dir_regs #(.DATA_W(DATA_W), .REC_W(REC_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && hit[d]), .sel(sel), .wdata(bus_wdata),
      .q_valid(valid_v[d]), .q_data(data_v[d]), .q_count(count_v[d]),
      .q_ready(ready_v[d]), .q_flush(flush_v[d]),
      .rd_word(word_v[d]), .done_o(done_v[d])
    );
  end

  tsq_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .hit(hit),
    .word_rx(word_v[DIR_RX]), .word_tx(word_v[DIR_TX]), .rdata(bus_rdata)
  );
endmodule

// File: rtl/tsq_regbank_chk.sv
module tsq_regbank_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] RX_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] TX_BASE = 8'h60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_take,
  input logic              tx_take,
  input logic [1:0]        done
);
  logic in_rx, in_tx, rx_ctrl_clr, tx_ctrl_clr;
  assign in_rx = bus_addr[ADDR_W-1:5] == RX_BASE[ADDR_W-1:5];
  assign in_tx = bus_addr[ADDR_W-1:5] == TX_BASE[ADDR_W-1:5];
  assign rx_ctrl_clr = bus_wr && bus_addr == RX_BASE && !bus_wdata[0];
  assign tx_ctrl_clr = bus_wr && bus_addr == TX_BASE && !bus_wdata[0];

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R5
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take |=> !rx_take) and (tx_take |=> !tx_take));
  // R5
  take_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take |=> done[0]) and (tx_take |=> done[1]));
  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ctrl_clr |=> !done[0]) and (tx_ctrl_clr |=> !done[1]));
  // R13
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ((!in_rx && !in_tx) || bus_addr[1:0] != 2'b00)) |=> bus_rdata == '0);
endmodule

bind tsq_regbank tsq_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RX_BASE(RX_BASE), .TX_BASE(TX_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_take(rxq_ready), .tx_take(txq_ready), .done(done_v)
);

// File: tb/tsq_regbank_test.sv
module tsq_regbank_test;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rxq_ready, txq_ready, rxq_flush, txq_flush;
  logic [1:0] q_valid;
  logic [127:0] q_data [2];
  logic [7:0] q_count [2];

  logic [127:0] qmem [2][16];
  int head [2];
  int tail [2];
  int pops [2];
  int n_tests = 0, n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  for (genvar d = 0; d < 2; d++) begin : g_q
    assign q_valid[d] = tail[d] != head[d];
    assign q_data[d]  = qmem[d][head[d] % 16];
    assign q_count[d] = 8'(tail[d] - head[d]);
  end

  tsq_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxq_valid(q_valid[0]), .rxq_ready(rxq_ready), .rxq_data(q_data[0]),
    .rxq_count(q_count[0]), .rxq_flush(rxq_flush),
    .txq_valid(q_valid[1]), .txq_ready(txq_ready), .txq_data(q_data[1]),
    .txq_count(q_count[1]), .txq_flush(txq_flush)
  );

  initial begin
    head[0] = 0; head[1] = 0; tail[0] = 0; tail[1] = 0; pops[0] = 0; pops[1] = 0;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rxq_ready) begin head[0] <= head[0] + 1; pops[0] <= pops[0] + 1; end
    if (txq_ready) begin head[1] <= head[1] + 1; pops[1] <= pops[1] + 1; end
  end

  always @(negedge clk) begin
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [127:0] mkrec(int d, int k);
    logic [31:0] a, b, c, e;
    a = 32'hA5000000 + 32'(d) * 32'h00100000 + 32'(k);
    b = 32'(k) * 32'h01010101;
    c = ~(32'(k) * 32'h00030007);
    e = 32'(k * 13 + d * 7 + 1);
    return {a, b, c, e};
  endfunction

  function automatic logic [7:0] base(int d);
    return d == 0 ? 8'h40 : 8'h60;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(int d, logic [127:0] r);
    qmem[d][tail[d] % 16] = r;
    tail[d] = tail[d] + 1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic poll(int d, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 20 && !ok; i++) begin
      rd(base(d), v);
      ok = v[0];
    end
  endtask

  task automatic read_rec(int d, output logic [127:0] r);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin
      rd(base(d) + 8'h10 + 8'(4 * i), w);
      r[127 - 32 * i -: 32] = w;
    end
  endtask

  task automatic fetch(int d, output bit ok, output logic [127:0] r);
    wr(base(d), 32'h0);
    wr(base(d), 32'h1);
    poll(d, ok);
    read_rec(d, r);
  endtask

  initial begin
    logic [31:0] v;
    logic [127:0] r;
    bit ok;
    int p0, p1;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 ready/flush", {28'd0, rxq_ready, txq_ready, rxq_flush, txq_flush}, 0);
    rst_n = 1;
    rd(8'h40, v); chk("R1 rx ctrl", v, 0);
    rd(8'h68, v); chk("R1 tx scratch", v, 0);
    rd(8'h5C, v); chk("R1 rx rec", v, 0);

    // R2: read data held without strobe
    rd(8'h40, v);
    @(negedge clk); bus_addr = 8'h44;
    @(negedge clk); chk("R2 hold", bus_rdata, v);

    // R11/R12: scratch sweep
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        wr(base(d) + 8'h08 + 8'(4 * s), 32'h13570000 + 32'(d * 16 + s));
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++) begin
        rd(base(d) + 8'h08 + 8'(4 * s), v);
        chk("R11 scratch", v, 32'h13570000 + 32'(d * 16 + s));
      end

    // R3: control readback, bit0 replaced by flag
    wr(8'h40, 32'hABCD1231);
    rd(8'h40, v); chk("R3 ctrl rb", v, 32'hABCD1230);
    wr(8'h40, 32'h0);
    wr(8'h60, 32'h00000002);
    chk("R3 tx flush out", {30'd0, txq_flush, rxq_flush}, 32'h2);
    rd(8'h60, v); chk("R3 tx ctrl rb", v, 32'h2);
    wr(8'h60, 32'h0);
    chk("R3 flush off", {31'd0, txq_flush}, 0);

    // R13: unmapped and misaligned sweep
    for (int a = 0; a < 256; a++) begin
      if ((a >= 8'h40 && a < 8'h80) && (a % 4 == 0)) continue;
      if (a % 4 == 0 || a % 37 == 1) begin
        wr(8'(a), 32'hFFFFFFFF);
        rd(8'(a), v); chk("R13 unmapped", v, 0);
      end
    end
    rd(8'h48, v); chk("R13 scratch intact", v, 32'h13570000);
    rd(8'h60, v); chk("R13 ctrl intact", v, 0);

    // R4/R5/R10/R12: fill both queues, sweep fetches
    for (int k = 0; k < 12; k++) begin push(0, mkrec(0, k)); push(1, mkrec(1, k)); end
    for (int d = 0; d < 2; d++) begin
      rd(base(d) + 8'h04, v); chk("R4 status", v, 32'd12);
    end
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 12; k++) begin
        p0 = pops[d]; p1 = pops[1 - d];
        fetch(d, ok, r);
        chk("R5 done", {31'd0, ok}, 1);
        chk("R5 one pop", pops[d] - p0, 1);
        chk("R12 other untouched", pops[1 - d] - p1, 0);
        for (int w = 0; w < 4; w++) begin
          logic [127:0] e;
          e = mkrec(d, k);
          chk("R10 rec word", r[127 - 32 * w -: 32], e[127 - 32 * w -: 32]);
        end
        rd(base(d) + 8'h04, v); chk("R4 status dec", v, 32'(11 - k));
      end

    // R6: arm on empty queue, then entry arrives
    p0 = pops[0];
    wr(8'h40, 0); wr(8'h40, 1);
    repeat (5) @(negedge clk);
    chk("R6 waits", pops[0] - p0, 0);
    push(0, mkrec(0, 40));
    poll(0, ok);
    chk("R6 done", {31'd0, ok}, 1);
    read_rec(0, r); chk("R6 rec", r[31:0], mkrec(0, 40) & 128'hFFFFFFFF);

    // R7: rewrite 1 while already 1
    push(0, mkrec(0, 41));
    p0 = pops[0];
    wr(8'h40, 1);
    repeat (3) @(negedge clk);
    chk("R7 no pop", pops[0] - p0, 0);
    rd(8'h40, v); chk("R7 flag kept", v, 1);

    // R8: clear while done, and clear in the cycle of a pending take
    wr(8'h40, 0);
    rd(8'h40, v); chk("R8 flag cleared", v, 0);
    head[0] = tail[0];
    wr(8'h40, 1);
    p0 = pops[0];
    @(negedge clk); bus_wr = 1; bus_addr = 8'h40; bus_wdata = 0;
    push(0, mkrec(0, 50));
    @(negedge clk); bus_wr = 0;
    repeat (2) @(negedge clk);
    chk("R8 clear wins no pop", pops[0] - p0, 0);
    chk("R8 count kept", {24'd0, q_count[0]}, 1);
    rd(8'h40, v); chk("R8 flag after", v, 0);
    fetch(0, ok, r);
    chk("R8 later fetch", r[127:96], mkrec(0, 50) >> 96);

    // R9: flush blocks take and disarms
    push(1, mkrec(1, 60));
    p1 = pops[1];
    wr(8'h60, 0);
    wr(8'h60, 3);
    repeat (3) @(negedge clk);
    chk("R9 no pop under flush", pops[1] - p1, 0);
    wr(8'h60, 1);
    repeat (3) @(negedge clk);
    chk("R9 disarmed", pops[1] - p1, 0);
    rd(8'h60, v); chk("R9 flag", v, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule